// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Unit

This block holds the pending-interrupt register and the interrupt mask register of a small 8-bit processor subsystem. It also drives the single interrupt request line to the core. Five event sources feed it:

| Bit | Source |
|-----|--------|
| 0 | vertical blank |
| 1 | display status |
| 2 | timer |
| 3 | serial |
| 4 | keypad |

A one-cycle pulse on a source input marks that source pending. Software reaches both registers over a byte-wide bus and can read and overwrite them.

The request line is high whenever some source is both pending and unmasked. A write to either register is therefore reflected on the line right away.

Reads of the pending register come from a shadow copy that trails the live register by one clock. The three unused upper bits always read as one. The core clears a single pending bit by presenting its index on an acknowledge port.

Top module: `irq_pend_mask_unit`

## Requirements
- R1: After synchronous reset the pending register reads 0xE0, the mask register reads 0x00 and `irq_req` is low.
- R2: A bus write to the pending register (`bus_sel`=0) stores the written byte ORed with 0xE0, so bits 7:5 always read as 1 and bits 4:0 take the written value.
- R3: `bus_rdata` for `bus_sel`=0 shows a shadow copy of the pending register, refreshed from it at every clock edge. In the cycle right after a change it still shows the previous value, and one cycle later it shows the new value.
- R4: A bus write to the mask register (`bus_sel`=1) stores all 8 bits, and they read back unchanged in the following cycle.
- R5: A high bit i (0..4) of `src_pulse` at a clock edge sets pending bit i. The bit order is the one in the table above.
- R6: `irq_req` is high in any cycle in which some bit i in 0..4 is set in both the pending and the mask registers. This includes the cycle right after a write to either register.
- R7: `irq_req` is low when the pending bits 4:0 ANDed with the mask register give zero. Mask bits 7:5 and pending bits 7:5 have no effect.
- R8: A pending keypad bit (bit 4) raises `irq_req` only while mask bit 4 is set.
- R9: A source pulse in the same cycle as a pending-register write leaves its bit set, even if the written byte has it clear.
- R10: `ack_valid` with index `ack_idx` in 0..4 clears that pending bit. An index of 5..7 changes nothing. A source pulse on the same bit in the same cycle wins over the acknowledge and leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 5 | Per-source event pulses, bit order as in R5 |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_sel | input | 1 | Register select: 0 pending, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (pending via shadow copy) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the pending bit to clear |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The request logic is tried with three kinds of pattern.

- Pending and mask values that share no low bit but do share upper bits. This shows that bits 7:5 are ignored.
- A single pulse on each source with the full low mask. This separates the five bit positions.
- The keypad source with its mask bit first clear and then set. This shows that the request is gated per bit.

Collision patterns check the ordering rules:

- a write together with a source pulse;
- an acknowledge together with a source pulse;
- an out-of-range acknowledge index.

Reading back right after a change, and again one cycle later, separates the shadow copy from the live pending register.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

    localparam int unsigned SRC_N  = 5;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    typedef enum int unsigned {
        SRC_VBLANK = 0,
        SRC_STATUS = 1,
        SRC_TIMER  = 2,
        SRC_SERIAL = 3,
        SRC_KEYPAD = 4
    } src_id_e;

    typedef struct packed {
        logic            we;
        reg_sel_e        sel;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    // Bits above the source field are hard-wired to one in the pending register.
    function automatic logic [BYTE_W-1:0] fixed_ones(input int unsigned n_src);
        logic [BYTE_W-1:0] m;
        for (int unsigned b = 0; b < BYTE_W; b++) begin
            m[b] = (b >= n_src);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
    parameter int unsigned NUM_SRC = irq_pm_pkg::SRC_N,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] ack_mask
);

    // One decoder slice per source; indices beyond the source count match nothing.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slice
        assign ack_mask[g] = ack_valid && (ack_idx == IDX_W'(g));
    end

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pm_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [DATA_W-1:0]  pend_q,
    output logic [DATA_W-1:0]  pend_shadow_q
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;
    localparam logic [DATA_W-1:0] ONES_MASK = fixed_ones(NUM_SRC);

    logic [DATA_W-1:0] set_wide;
    logic [DATA_W-1:0] clr_wide;
    logic [DATA_W-1:0] base_val;
    logic [DATA_W-1:0] pend_d;

    assign set_wide = {{PAD_W{1'b0}}, set_vec};
    assign clr_wide = {{PAD_W{1'b0}}, clr_vec};

    // Order: bus write replaces, acknowledge clears, source pulse sets last (wins).
    always_comb begin
        base_val = wr_en ? (wr_data | ONES_MASK) : pend_q;
        pend_d   = (base_val & ~clr_wide) | set_wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q        <= ONES_MASK;
            pend_shadow_q <= ONES_MASK;
        end else begin
            pend_q        <= pend_d;
            pend_shadow_q <= pend_q;
        end
    end

    // R2: a clean write lands with the upper bits forced high
    a_r2_write_value: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (set_vec == '0) && (clr_vec == '0)) |=> (pend_q == ($past(wr_data) | ONES_MASK)));

    // R3: the readable copy trails the live register by one cycle
    a_r3_shadow_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend_shadow_q == $past(pend_q)));

    // R9: every pulsed source is pending in the next cycle, whatever else happened
    a_r9_src_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q[NUM_SRC-1:0] & $past(set_vec)) == $past(set_vec)));

    // R10: an acknowledged bit with no competing pulse or write is cleared
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec != '0) && ((clr_vec & set_vec) == '0) && !wr_en)
        |=> ((pend_q[NUM_SRC-1:0] & $past(clr_vec)) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned DATA_W = irq_pm_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wr_data;
        end
    end

    // R4: all written bits are kept
    a_r4_mask_store: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mask_q == $past(wr_data)));

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int unsigned NUM_SRC = irq_pm_pkg::SRC_N,
    parameter int unsigned DATA_W  = irq_pm_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pend,
    input  logic [DATA_W-1:0] mask,
    output logic              req
);

    localparam int unsigned KEY_BIT = irq_pm_pkg::SRC_KEYPAD;

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
        assign hit[g] = pend[g] & mask[g];
    end

    assign req = |hit;

    // R8: a pending keypad bit alone never raises the request while its mask bit is clear
    a_r8_keypad_gated: assert property (@(posedge clk) disable iff (rst)
        (pend[KEY_BIT] && !mask[KEY_BIT] && ((pend[KEY_BIT-1:0] & mask[KEY_BIT-1:0]) == '0)) |-> !req);

endmodule

// File: rtl/irq_pend_mask_unit.sv
module irq_pend_mask_unit
    import irq_pm_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = BYTE_W,
    parameter int unsigned IDX_W   = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               bus_we,
    input  logic               bus_sel,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic               irq_req
);

    bus_req_t           bus;
    logic [NUM_SRC-1:0] ack_mask;
    logic [DATA_W-1:0]  pend_live;
    logic [DATA_W-1:0]  pend_view;
    logic [DATA_W-1:0]  mask_live;
    logic               pend_wr;
    logic               mask_wr;

    assign bus.we    = bus_we;
    assign bus.sel   = reg_sel_e'(bus_sel);
    assign bus.wdata = bus_wdata;

    assign pend_wr = bus.we && (bus.sel == SEL_PEND);
    assign mask_wr = bus.we && (bus.sel == SEL_MASK);

    irq_ack_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_ack (
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .ack_mask  (ack_mask)
    );

    irq_pend_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_pend (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (pend_wr),
        .wr_data       (bus.wdata),
        .set_vec       (src_pulse),
        .clr_vec       (ack_mask),
        .pend_q        (pend_live),
        .pend_shadow_q (pend_view)
    );

    irq_mask_reg #(.DATA_W(DATA_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr),
        .wr_data (bus.wdata),
        .mask_q  (mask_live)
    );

    irq_req_gen #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_req (
        .clk  (clk),
        .rst  (rst),
        .pend (pend_live),
        .mask (mask_live),
        .req  (irq_req)
    );

    assign bus_rdata = (bus.sel == SEL_MASK) ? mask_live : pend_view;

endmodule

// File: tb/irq_pend_mask_unit_tb_top.sv
module irq_pend_mask_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_pulse = '0;
    logic       bus_we = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       irq_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_pend_mask_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_pulse (src_pulse),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .irq_req   (irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // drive for one edge, return just after that edge (at the falling edge)
    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk);
        src_pulse = m;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic ack(input logic [2:0] idx, input logic [4:0] m);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = idx; src_pulse = m;
        @(negedge clk);
        ack_valid = 1'b0; src_pulse = '0;
    endtask

    task automatic peek(input logic sel, output logic [7:0] v);
        bus_sel = sel;
        #1 v = bus_rdata;
    endtask

    // wait one more edge so the pending shadow copy has caught up
    task automatic peek_pend_settled(output logic [7:0] v);
        @(negedge clk);
        peek(1'b0, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(1'b0, v); chk("R1 pending reset", v, 8'hE0);
        peek(1'b1, v); chk("R1 mask reset", v, 8'h00);
        chk("R1 irq reset", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_pend_write;
        logic [7:0] v;
        wr(1'b0, 8'h00);
        peek_pend_settled(v); chk("R2 write zero", v, 8'hE0);
        wr(1'b0, 8'h0A);
        peek(1'b0, v); chk("R3 old value right after write", v, 8'hE0);
        peek_pend_settled(v); chk("R3/R2 new value one cycle later", v, 8'hEA);
    endtask

    task automatic t_mask_and_req;
        logic [7:0] v;
        wr(1'b1, 8'hA5);
        peek(1'b1, v); chk("R4 mask readback", v, 8'hA5);
        chk("R7 no common low bit", {7'd0, irq_req}, 8'h00);
        wr(1'b1, 8'h08);
        chk("R6 request after mask write", {7'd0, irq_req}, 8'h01);
        wr(1'b0, 8'h00);
        chk("R7 request drops after pending write", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_sources;
        logic [7:0] v;
        wr(1'b1, 8'h1F);
        for (int i = 0; i < 5; i++) begin
            wr(1'b0, 8'h00);
            pulse(5'(1 << i));
            chk($sformatf("R5/R6 irq after source %0d", i), {7'd0, irq_req}, 8'h01);
            peek_pend_settled(v);
            chk($sformatf("R5 pending after source %0d", i), v, 8'hE0 | 8'(1 << i));
        end
    endtask

    task automatic t_keypad;
        logic [7:0] v;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h0F);
        pulse(5'h10);
        chk("R8 keypad masked", {7'd0, irq_req}, 8'h00);
        peek_pend_settled(v); chk("R8 keypad pending", v, 8'hF0);
        wr(1'b1, 8'h10);
        chk("R8 keypad unmasked", {7'd0, irq_req}, 8'h01);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        @(negedge clk);
        bus_we = 1'b1; bus_sel = 1'b0; bus_wdata = 8'h00; src_pulse = 5'h04;
        @(negedge clk);
        bus_we = 1'b0; src_pulse = '0;
        peek_pend_settled(v); chk("R9 pulse wins over write", v, 8'hE4);
    endtask

    task automatic t_ack;
        logic [7:0] v;
        wr(1'b0, 8'h1F);
        ack(3'd3, 5'h00);
        peek_pend_settled(v); chk("R10 ack bit 3", v, 8'hF7);
        ack(3'd6, 5'h00);
        peek_pend_settled(v); chk("R10 out-of-range index", v, 8'hF7);
        ack(3'd1, 5'h02);
        peek_pend_settled(v); chk("R10 pulse wins over ack", v, 8'hF7);
        ack(3'd0, 5'h00);
        peek_pend_settled(v); chk("R10 ack bit 0", v, 8'hF6);
        chk("R6 keypad still pending and unmasked", {7'd0, irq_req}, 8'h01);
        ack(3'd4, 5'h00);
        chk("R7 request drops after ack", {7'd0, irq_req}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pend_write();
        t_mask_and_req();
        t_sources();
        t_keypad();
        t_priority();
        t_ack();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule